// File: doc/BRIEF.md
# Instruction Miss Region Recorder

This block records the instruction fetches that miss the second-level cache, so that a later prefetcher can replay them. Each miss arrives as a virtual address. The block folds that address into a 1 KB region, which is named by its aligned tag. A small fully associative buffer holds up to 16 regions, each with a 16-bit mask that has one bit per 64-byte line. The buffer is kept in arrival order. A miss to a region that is already held only sets that region's line bit. A miss to a new region takes a free slot. When no slot is free, the oldest region is pushed out to a log in memory and the new region takes its place at the tail.

Software starts a recording by pulsing a start input with the base address of the log area. Each log entry written advances the write address by a fixed entry size. The log keeps the order in which regions were first touched. It does not keep the order of the lines inside a region. A region that has been pushed out is never brought back, so the same tag can appear in the log more than once. At the end of a run, a flush request drains every held region in arrival order. The block then pulses a done flag and presents the total number of log entries written.

Top module: `imr_recorder`

## Requirements
- R1: After reset, miss_ready, wr_valid and flush_done are low and flush_count is zero.
- R2: A rec_start pulse while the block is idle latches log_base, clears the buffer and the entry count, and begins recording. The first log entry is written at log_base. Misses are not accepted while the block is idle.
- R3: A miss is split into a region tag, miss_vaddr[31:10], and a line index, miss_vaddr[9:6]. When the tag is already held, bit `line` of that region's mask is set and no log write occurs.
- R4: A miss to a new region while fewer than 16 regions are held takes a free slot, and no log write occurs.
- R5: A miss to a new region while 16 regions are held writes out the oldest region, with wr_tag set to its tag and wr_bits set to its line mask. The new region enters at the tail with only its own line bit set.
- R6: Each accepted log write, where wr_valid and wr_ready are both high, advances the next write address by 8 bytes. Entry n of a recording is therefore written at log_base + 8*n.
- R7: The log lists regions in the order of their first touch. A region that misses again after it was written out appears again in the log.
- R8: While wr_valid is high and wr_ready is low, miss_ready is low and the pending log entry stays unchanged. No accepted miss is lost.
- R9: A flush_req while recording writes out all held regions, oldest first. It then gives a one-cycle flush_done with flush_count equal to the number of entries written since rec_start, and the block returns to idle. A miss accepted in the same cycle as flush_req is part of the drained contents.
- R10: A rec_start pulse while recording has no effect on the log address or on the held regions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rec_start | input | 1 | Start pulse for a recording |
| log_base | input | 32 | Base address of the log area |
| miss_valid | input | 1 | A miss address is offered |
| miss_vaddr | input | 32 | Virtual address of the missing fetch |
| miss_ready | output | 1 | The offered miss is taken this cycle |
| flush_req | input | 1 | Request to drain the buffer and stop |
| flush_done | output | 1 | One-cycle pulse when the drain has finished |
| flush_count | output | 16 | Number of log entries written since start |
| wr_valid | output | 1 | A log entry is offered to memory |
| wr_ready | input | 1 | Memory takes the offered entry |
| wr_addr | output | 32 | Address of the offered log entry |
| wr_tag | output | 22 | Region tag of the offered entry |
| wr_bits | output | 16 | Line mask of the offered entry |

## Verification
Two things can happen in the same cycle. A miss that forces an eviction can be accepted while the write port completes the previous log entry. A flush request can arrive together with an accepted miss. The first case is provoked by twenty distinct regions sent while memory accepts only one cycle in four. Each eviction then lands exactly on a handshake, and the result is judged by the exact order, addresses and masks of the whole log. The second case raises flush_req alongside a final miss. It is judged by that miss appearing as the last drained entry and by the final count.

// File: rtl/imr_pkg.sv
`timescale 1ns/1ps
package imr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FLUSH = 2'd2
  } rec_state_e;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_SET  = 2'd1,
    OP_PUSH = 2'd2,
    OP_POP  = 2'd3
  } store_op_e;
endpackage

// File: rtl/imr_region_match.sv
`timescale 1ns/1ps
module imr_region_match #(
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 22,
  parameter int IDX_W   = 4
) (
  input  logic [ENTRIES-1:0][TAG_W-1:0] tags,
  input  logic [ENTRIES-1:0]            vld,
  input  logic [TAG_W-1:0]              probe,
  output logic                          hit,
  output logic [IDX_W-1:0]              idx
);
  logic [ENTRIES-1:0] eq;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cmp
      assign eq[g] = vld[g] && (tags[g] == probe);
    end
  endgenerate

  always_comb begin
    hit = |eq;
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (eq[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/imr_region_store.sv
`timescale 1ns/1ps
module imr_region_store
  import imr_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 22,
  parameter int LINES   = 16,
  parameter int IDX_W   = 4,
  parameter int LIDX_W  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clear,
  input  store_op_e                     op,
  input  logic [IDX_W-1:0]              set_idx,
  input  logic [TAG_W-1:0]              new_tag,
  input  logic [LIDX_W-1:0]             line_idx,
  output logic [ENTRIES-1:0][TAG_W-1:0] tags,
  output logic [ENTRIES-1:0]            vld,
  output logic [TAG_W-1:0]              head_tag,
  output logic [LINES-1:0]              head_bits,
  output logic                          full,
  output logic                          empty
);
  localparam int CNT_W = $clog2(ENTRIES + 1);

  logic [ENTRIES-1:0][TAG_W-1:0] tag_q, tag_d;
  logic [ENTRIES-1:0][LINES-1:0] bits_q, bits_d;
  logic [ENTRIES-1:0]            vld_q, vld_d;
  logic [IDX_W-1:0]              head_q, head_d;
  logic [CNT_W-1:0]              cnt_q, cnt_d;
  logic [IDX_W-1:0]              tail;
  logic [LINES-1:0]              line_mask;

  function automatic logic [IDX_W-1:0] wrap_inc(input logic [IDX_W-1:0] p);
    if (p == IDX_W'(ENTRIES - 1)) return '0;
    return p + 1'b1;
  endfunction

  always_comb begin
    int s;
    s = int'(head_q) + int'(cnt_q);
    if (s >= ENTRIES) s = s - ENTRIES;
    tail = IDX_W'(s);
  end

  assign line_mask = LINES'(1) << line_idx;
  assign full      = (cnt_q == CNT_W'(ENTRIES));
  assign empty     = (cnt_q == '0);
  assign tags      = tag_q;
  assign vld       = vld_q;
  assign head_tag  = tag_q[head_q];
  assign head_bits = bits_q[head_q];

  always_comb begin
    tag_d  = tag_q;
    bits_d = bits_q;
    vld_d  = vld_q;
    head_d = head_q;
    cnt_d  = cnt_q;
    if (clear) begin
      vld_d  = '0;
      head_d = '0;
      cnt_d  = '0;
    end else begin
      unique case (op)
        OP_SET: bits_d[set_idx] = bits_q[set_idx] | line_mask;
        OP_PUSH: begin
          if (full) begin
            tag_d[head_q]  = new_tag;
            bits_d[head_q] = line_mask;
            head_d         = wrap_inc(head_q);
          end else begin
            tag_d[tail]  = new_tag;
            bits_d[tail] = line_mask;
            vld_d[tail]  = 1'b1;
            cnt_d        = cnt_q + 1'b1;
          end
        end
        OP_POP: begin
          if (!empty) begin
            vld_d[head_q] = 1'b0;
            head_d        = wrap_inc(head_q);
            cnt_d         = cnt_q - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      head_q <= '0;
      cnt_q  <= '0;
    end else begin
      vld_q  <= vld_d;
      head_q <= head_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (op != OP_NONE) begin
      tag_q  <= tag_d;
      bits_q <= bits_d;
    end
  end
endmodule

// File: rtl/imr_log_writer.sv
`timescale 1ns/1ps
module imr_log_writer #(
  parameter int AW          = 32,
  parameter int TAG_W       = 22,
  parameter int LINES       = 16,
  parameter int ENTRY_BYTES = 8,
  parameter int LCNT_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AW-1:0]     base,
  input  logic              load,
  input  logic [TAG_W-1:0]  ld_tag,
  input  logic [LINES-1:0]  ld_bits,
  input  logic              wr_ready,
  output logic              wr_valid,
  output logic [AW-1:0]     wr_addr,
  output logic [TAG_W-1:0]  wr_tag,
  output logic [LINES-1:0]  wr_bits,
  output logic              free,
  output logic [LCNT_W-1:0] log_count
);
  logic              vld_q, vld_d;
  logic [AW-1:0]     addr_q, addr_d;
  logic [LCNT_W-1:0] cnt_q, cnt_d;
  logic [TAG_W-1:0]  tag_q;
  logic [LINES-1:0]  bits_q;
  logic              xfer;

  assign xfer = vld_q && wr_ready;
  assign free = !vld_q || wr_ready;

  always_comb begin
    vld_d  = vld_q;
    addr_d = addr_q;
    cnt_d  = cnt_q;
    if (xfer) begin
      vld_d  = 1'b0;
      addr_d = addr_q + AW'(ENTRY_BYTES);
      cnt_d  = cnt_q + 1'b1;
    end
    if (load) vld_d = 1'b1;
    if (start) begin
      addr_d = base;
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      vld_q  <= vld_d;
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      tag_q  <= ld_tag;
      bits_q <= ld_bits;
    end
  end

  assign wr_valid  = vld_q;
  assign wr_addr   = addr_q;
  assign wr_tag    = tag_q;
  assign wr_bits   = bits_q;
  assign log_count = cnt_q;
endmodule

// File: rtl/imr_recorder.sv
`timescale 1ns/1ps
module imr_recorder
  import imr_pkg::*;
#(
  parameter int VA_W         = 32,
  parameter int AW           = 32,
  parameter int ENTRIES      = 16,
  parameter int LINE_BYTES   = 64,
  parameter int REGION_BYTES = 1024,
  parameter int ENTRY_BYTES  = 8,
  parameter int LCNT_W       = 16
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      rec_start,
  input  logic [AW-1:0]                             log_base,
  input  logic                                      miss_valid,
  input  logic [VA_W-1:0]                           miss_vaddr,
  output logic                                      miss_ready,
  input  logic                                      flush_req,
  output logic                                      flush_done,
  output logic [LCNT_W-1:0]                         flush_count,
  output logic                                      wr_valid,
  input  logic                                      wr_ready,
  output logic [AW-1:0]                             wr_addr,
  output logic [VA_W-$clog2(REGION_BYTES)-1:0]      wr_tag,
  output logic [REGION_BYTES/LINE_BYTES-1:0]        wr_bits
);
  localparam int LINE_LSB = $clog2(LINE_BYTES);
  localparam int REG_LSB  = $clog2(REGION_BYTES);
  localparam int TAG_W    = VA_W - REG_LSB;
  localparam int LINES    = REGION_BYTES / LINE_BYTES;
  localparam int LIDX_W   = REG_LSB - LINE_LSB;
  localparam int IDX_W    = $clog2(ENTRIES);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  rec_state_e state_q, state_d;
  logic       done_q, done_d;
  store_op_e  op;
  logic       clear, start, wr_load, wr_free, accept;
  logic       hit, full, empty;
  logic [IDX_W-1:0]              hit_idx;
  logic [ENTRIES-1:0][TAG_W-1:0] tags;
  logic [ENTRIES-1:0]            vld;
  logic [TAG_W-1:0]              head_tag, miss_tag;
  logic [LINES-1:0]              head_bits;
  logic [LIDX_W-1:0]             miss_line;
  logic                          miss_unused_lo;

  assign miss_tag       = miss_vaddr[VA_W-1:REG_LSB];
  assign miss_line      = miss_vaddr[REG_LSB-1:LINE_LSB];
  assign miss_unused_lo = ^miss_vaddr[LINE_LSB-1:0];

  assign miss_ready = (state_q == ST_RUN) && wr_free;
  assign accept     = miss_valid && miss_ready;

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    op      = OP_NONE;
    clear   = 1'b0;
    start   = 1'b0;
    wr_load = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (rec_start) begin
          start   = 1'b1;
          clear   = 1'b1;
          state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        if (accept) begin
          if (hit) begin
            op = OP_SET;
          end else begin
            op      = OP_PUSH;
            wr_load = full;
          end
        end
        if (flush_req) state_d = ST_FLUSH;
      end
      ST_FLUSH: begin
        if (!empty) begin
          if (wr_free) begin
            op      = OP_POP;
            wr_load = 1'b1;
          end
        end else if (!wr_valid) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign flush_done = done_q;

  imr_region_match #(
    .ENTRIES(ENTRIES), .TAG_W(TAG_W), .IDX_W(IDX_W)
  ) u_match (
    .tags (tags),
    .vld  (vld),
    .probe(miss_tag),
    .hit  (hit),
    .idx  (hit_idx)
  );

  imr_region_store #(
    .ENTRIES(ENTRIES), .TAG_W(TAG_W), .LINES(LINES),
    .IDX_W(IDX_W), .LIDX_W(LIDX_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .clear    (clear),
    .op       (op),
    .set_idx  (hit_idx),
    .new_tag  (miss_tag),
    .line_idx (miss_line),
    .tags     (tags),
    .vld      (vld),
    .head_tag (head_tag),
    .head_bits(head_bits),
    .full     (full),
    .empty    (empty)
  );

  imr_log_writer #(
    .AW(AW), .TAG_W(TAG_W), .LINES(LINES),
    .ENTRY_BYTES(ENTRY_BYTES), .LCNT_W(LCNT_W)
  ) u_writer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start    (start),
    .base     (log_base),
    .load     (wr_load),
    .ld_tag   (head_tag),
    .ld_bits  (head_bits),
    .wr_ready (wr_ready),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_tag   (wr_tag),
    .wr_bits  (wr_bits),
    .free     (wr_free),
    .log_count(flush_count)
  );
endmodule

// File: rtl/imr_recorder_chk.sv
`timescale 1ns/1ps
module imr_recorder_chk #(
  parameter int AW          = 32,
  parameter int TAG_W       = 22,
  parameter int LINES       = 16,
  parameter int ENTRY_BYTES = 8,
  parameter int LCNT_W      = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              miss_ready,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [AW-1:0]     wr_addr,
  input logic [TAG_W-1:0]  wr_tag,
  input logic [LINES-1:0]  wr_bits,
  input logic              flush_done,
  input logic [LCNT_W-1:0] flush_count
);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_tag) && $stable(wr_bits)));

  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |-> !miss_ready);

  p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> (!wr_valid || (wr_addr == $past(wr_addr) + AW'(ENTRY_BYTES))));

  p_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_bits != '0));

  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |=> !flush_done);

  p_drained_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |-> (!wr_valid && !miss_ready && $stable(flush_count)));
endmodule

bind imr_recorder imr_recorder_chk #(
  .AW(AW), .TAG_W(VA_W - $clog2(REGION_BYTES)), .LINES(REGION_BYTES / LINE_BYTES),
  .ENTRY_BYTES(ENTRY_BYTES), .LCNT_W(LCNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .miss_ready (miss_ready),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .wr_addr    (wr_addr),
  .wr_tag     (wr_tag),
  .wr_bits    (wr_bits),
  .flush_done (flush_done),
  .flush_count(flush_count)
);

// File: tb/imr_recorder_test.sv
`timescale 1ns/1ps
module imr_recorder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rec_start = 1'b0;
  logic [31:0] log_base = '0;
  logic        miss_valid = 1'b0;
  logic [31:0] miss_vaddr = '0;
  logic        miss_ready;
  logic        flush_req = 1'b0;
  logic        flush_done;
  logic [15:0] flush_count;
  logic        wr_valid;
  logic        wr_ready;
  logic [31:0] wr_addr;
  logic [21:0] wr_tag;
  logic [15:0] wr_bits;

  int errors = 0;
  int checks = 0;

  imr_recorder uut (
    .clk(clk), .rst_n(rst_n), .rec_start(rec_start), .log_base(log_base),
    .miss_valid(miss_valid), .miss_vaddr(miss_vaddr), .miss_ready(miss_ready),
    .flush_req(flush_req), .flush_done(flush_done), .flush_count(flush_count),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_tag(wr_tag), .wr_bits(wr_bits)
  );

  always #10 clk = ~clk;

  // write-port model and log capture
  int          ready_mode = 0;
  int          rcnt = 0;
  int          n_log = 0;
  int          stall_viol = 0;
  int          hold_viol = 0;
  int          stall_seen = 0;
  logic        held = 1'b0;
  logic [31:0] h_addr;
  logic [21:0] h_tag;
  logic [15:0] h_bits;
  logic [21:0] log_tag  [0:63];
  logic [15:0] log_bits [0:63];
  logic [31:0] log_addr [0:63];

  always @(negedge clk) begin
    rcnt = rcnt + 1;
    wr_ready = (ready_mode == 0) ? 1'b1 : ((rcnt % 4) == 0);
    #1;
    if (wr_valid && !wr_ready) stall_seen++;
    if (wr_valid && !wr_ready && miss_ready) stall_viol++;
    if (held && (!wr_valid || wr_addr != h_addr || wr_tag != h_tag || wr_bits != h_bits)) hold_viol++;
    held   = wr_valid && !wr_ready;
    h_addr = wr_addr;
    h_tag  = wr_tag;
    h_bits = wr_bits;
    if (wr_valid && wr_ready) begin
      if (n_log < 64) begin
        log_tag[n_log]  = wr_tag;
        log_bits[n_log] = wr_bits;
        log_addr[n_log] = wr_addr;
      end
      n_log++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] va(input int tag, input int line);
    return (32'(tag) << 10) | (32'(line) << 6);
  endfunction

  task automatic begin_rec(input logic [31:0] base);
    n_log = 0;
    @(negedge clk);
    rec_start = 1'b1;
    log_base  = base;
    @(negedge clk);
    rec_start = 1'b0;
  endtask

  task automatic send_miss(input int tag, input int line, input bit with_flush);
    int guard;
    guard = 0;
    @(negedge clk);
    miss_valid = 1'b1;
    miss_vaddr = va(tag, line);
    flush_req  = with_flush;
    #2;
    while (!miss_ready && guard < 1000) begin
      @(negedge clk);
      #2;
      guard++;
    end
    @(negedge clk);
    miss_valid = 1'b0;
    flush_req  = 1'b0;
  endtask

  task automatic wait_done(output int cnt, input bit requested);
    int guard;
    bit got;
    guard = 0;
    got = 0;
    cnt = -1;
    if (!requested) begin
      @(negedge clk);
      flush_req = 1'b1;
      @(negedge clk);
      flush_req = 1'b0;
    end
    while (!got && guard < 2000) begin
      @(negedge clk);
      #2;
      if (flush_done) begin
        got = 1;
        cnt = int'(flush_count);
      end
      guard++;
    end
    @(negedge clk);
    #2;
  endtask

  task automatic t_reset;
    #2;
    check(miss_ready == 1'b0, "R1", "miss_ready", miss_ready, 0);
    check(wr_valid == 1'b0, "R1", "wr_valid", wr_valid, 0);
    check(flush_done == 1'b0, "R1", "flush_done", flush_done, 0);
    check(flush_count == 16'd0, "R1", "flush_count", flush_count, 0);
  endtask

  task automatic t_merge;
    int cnt;
    begin_rec(32'h1000);
    send_miss(5, 1, 0);
    send_miss(5, 3, 0);
    send_miss(7, 0, 0);
    send_miss(5, 15, 0);
    repeat (3) @(negedge clk);
    check(n_log == 0, "R3", "writes before flush", n_log, 0);
    wait_done(cnt, 0);
    check(n_log == 2, "R9", "drained entries", n_log, 2);
    check(cnt == 2, "R9", "flush_count", cnt, 2);
    check(log_tag[0] == 22'd5, "R4", "first tag", log_tag[0], 5);
    check(log_bits[0] == 16'h800a, "R3", "merged mask", log_bits[0], 16'h800a);
    check(log_addr[0] == 32'h1000, "R2", "first address", log_addr[0], 32'h1000);
    check(log_tag[1] == 22'd7 && log_bits[1] == 16'h0001, "R4", "second entry", log_tag[1], 7);
    check(log_addr[1] == 32'h1008, "R6", "second address", log_addr[1], 32'h1008);
    #2;
    check(miss_ready == 1'b0, "R2", "idle miss_ready", miss_ready, 0);
  endtask

  task automatic t_evict;
    int cnt;
    bit ok;
    begin_rec(32'h2000);
    for (int i = 0; i < 16; i++) begin
      send_miss(100 + i, i, 0);
      if (i == 3) begin
        @(negedge clk);
        rec_start = 1'b1;
        log_base  = 32'h9000;
        @(negedge clk);
        rec_start = 1'b0;
      end
    end
    repeat (3) @(negedge clk);
    check(n_log == 0, "R4", "no write while filling", n_log, 0);
    send_miss(200, 2, 0);
    repeat (3) @(negedge clk);
    check(n_log == 1, "R5", "eviction count", n_log, 1);
    check(log_tag[0] == 22'd100 && log_bits[0] == 16'h0001, "R5", "evicted oldest", log_tag[0], 100);
    check(log_addr[0] == 32'h2000, "R10", "base kept", log_addr[0], 32'h2000);
    send_miss(101, 9, 0);
    repeat (3) @(negedge clk);
    check(n_log == 1, "R3", "hit does not write", n_log, 1);
    send_miss(100, 4, 0);
    repeat (3) @(negedge clk);
    check(log_tag[1] == 22'd101 && log_bits[1] == 16'h0202, "R5", "second eviction", log_bits[1], 16'h0202);
    wait_done(cnt, 0);
    check(cnt == 18, "R9", "flush_count", cnt, 18);
    ok = (n_log == 18);
    for (int k = 2; k < 16 && ok; k++)
      ok = (log_tag[k] == 22'(100 + k)) && (log_bits[k] == (16'h1 << k));
    check(ok, "R7", "first-touch order", n_log, 18);
    check(log_tag[16] == 22'd200 && log_bits[16] == 16'h0004, "R5", "new entry mask", log_bits[16], 16'h0004);
    check(log_tag[17] == 22'd100 && log_bits[17] == 16'h0010, "R7", "repeat region", log_tag[17], 100);
    ok = 1;
    for (int k = 0; k < 18; k++) ok = ok && (log_addr[k] == 32'h2000 + 32'(8 * k));
    check(ok, "R6", "address sequence", log_addr[17], 32'h2088);
  endtask

  task automatic t_backpressure;
    int cnt;
    bit ok;
    ready_mode = 1;
    stall_viol = 0;
    hold_viol  = 0;
    stall_seen = 0;
    begin_rec(32'h3000);
    for (int i = 0; i < 20; i++) send_miss(300 + i, i % 16, 0);
    wait_done(cnt, 0);
    ready_mode = 0;
    check(stall_seen > 0, "R8", "stall provoked", stall_seen, 1);
    check(stall_viol == 0, "R8", "miss_ready during stall", stall_viol, 0);
    check(hold_viol == 0, "R8", "entry held", hold_viol, 0);
    check(cnt == 20, "R9", "flush_count", cnt, 20);
    ok = (n_log == 20);
    for (int k = 0; k < 20 && ok; k++)
      ok = (log_tag[k] == 22'(300 + k)) && (log_bits[k] == (16'h1 << (k % 16)))
           && (log_addr[k] == 32'h3000 + 32'(8 * k));
    check(ok, "R8", "no miss lost", n_log, 20);
  endtask

  task automatic t_flush_with_miss;
    int cnt;
    begin_rec(32'h4000);
    send_miss(1, 0, 0);
    send_miss(2, 1, 0);
    send_miss(3, 2, 1);
    wait_done(cnt, 1);
    check(cnt == 3, "R9", "count with same-cycle miss", cnt, 3);
    check(n_log == 3 && log_tag[2] == 22'd3 && log_bits[2] == 16'h0004,
          "R9", "same-cycle miss drained", log_tag[2], 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_merge();
    t_evict();
    t_backpressure();
    t_flush_with_miss();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule